// File: doc/BRIEF.md
# Slave Multi-Format Audio Serial Transmitter

This block places a pair of stereo PCM samples onto one serial data line. Both the bit clock and the frame (word-select) clock come from outside, so the block only follows them: it samples the frame clock on bit-clock rising edges, finds its transitions, counts bit slots within each half-frame, and changes the data line on bit-clock falling edges.

One shifter serves three framings. Left-justified and I2S framing start the word at a fixed slot after a frame edge. Right-justified framing must end the word on the last slot before the next frame edge. To do that, the block measures the length of the previous half-frame in bit clocks and starts shifting early enough for the LSB to land in that last slot. The word length is 16, 20 or 24 bits. A shorter word is taken from the upper bits of the 24-bit input. Slots that carry no data bit are driven low.

A sample pair is captured by a load strobe in the bit-clock domain and is repeated on every frame until the next load.

Top module: `pcm_serial_tx`

## Requirements
- R1: While `rst_n` is low, `sdata` is 0. After reset it stays 0 until the first frame-clock transition has been sampled, in every framing.
- R2: `frame_clk` is sampled on rising edges of `bclk`. `sdata` changes only on falling edges of `bclk`, so it is stable across every rising edge. The slot counter restarts at slot 1 on the rising edge that first sees a new frame-clock level.
- R3: With `fmt_sel` = 1 (left-justified), the MSB is valid at the first rising edge of a half-frame. The lower bits follow on the next rising edges, one per edge, and the remaining slots of the half-frame are 0.
- R4: With `fmt_sel` = 2 or 3 (I2S), slot 1 is 0 and the MSB is valid at the second rising edge of a half-frame. The lower bits follow in order, and the remaining slots are 0.
- R5: With `fmt_sel` = 0 (right-justified), the word fills the last W slots of a half-frame of N slots, MSB first. The LSB is valid at the last rising edge before the next frame-clock transition, and slots 1 to N-W are 0.
- R6: In left- and right-justified framing, frame clock high carries the left sample and low carries the right sample. In I2S framing, frame clock low carries the left sample and high carries the right sample.
- R7: `wlen_sel` selects the word length W: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 gives 24 bits. A word shorter than 24 bits is bits 23 down to 24-W of the sample.
- R8: Left- and right-justified framing output only after one complete half-frame, bounded by two sampled transitions, has been measured. The first half-frame after reset is all 0, and slot 1 of the second half-frame is 0.
- R9: In right-justified framing, a measured half-frame shorter than W slots produces an all-zero line.
- R10: A rising edge with `load` high captures both `left_smp` and `right_smp`. Without `load`, changes on those inputs have no effect on `sdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the external clock master |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_clk | input | 1 | Frame clock; its level selects the channel on the line |
| load | input | 1 | Capture strobe for the sample pair |
| left_smp | input | 24 | Left-channel sample, two's complement |
| right_smp | input | 24 | Right-channel sample, two's complement |
| fmt_sel | input | 2 | Framing: 0 right-justified, 1 left-justified, 2 or 3 I2S |
| wlen_sel | input | 2 | Word length: 0 is 16, 1 is 20, 2 or 3 is 24 bits |
| sdata | output | 1 | Serial data line |

## Verification
The assertions assume the following about the inputs:
- the frame clock changes only between bit-clock rising edges;
- `fmt_sel` and `wlen_sel` are held steady while frames run;
- in I2S framing, every half-frame has at least W+1 slots and all half-frames have the same length.

Under these conditions, slot 1 of every I2S half-frame is 0, and a missing measurement keeps the justified framings silent. The stimulus respects them:
- the frame clock is driven just after falling edges;
- a reset comes between any two configurations;
- each run uses one fixed half-frame length, chosen at or above W+1 for I2S.

The right-justified short-frame case is the one run that deliberately uses a half-frame shorter than the word.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ      = 2'd0,
    FMT_LJ      = 2'd1,
    FMT_I2S     = 2'd2,
    FMT_I2S_ALT = 2'd3
  } frame_fmt_e;

  // Word length in bits for a select code, relative to the full sample width.
  function automatic int word_bits(input logic [1:0] sel, input int full_w);
    case (sel)
      2'd0:    return full_w - 8;
      2'd1:    return full_w - 4;
      default: return full_w;
    endcase
  endfunction

endpackage

// File: rtl/pcm_rst_sync.sv
module pcm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/pcm_frame_track.sv
module pcm_frame_track #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_clk,
  output logic          trans,
  output logic          seen_eff,
  output logic          ok_eff,
  output logic [PW-1:0] len_eff,
  output logic [PW:0]   nxt_idx,
  output logic          nxt_level,
  output logic          seen_q,
  output logic          ok_q,
  output logic [PW-1:0] pos_q
);

  localparam logic [PW-1:0] POS_ONE = PW'(1);
  localparam logic [PW:0]   IDX_ONE = (PW + 1)'(1);
  localparam logic [PW-1:0] POS_MAX = '1;

  logic          frame_q;
  logic          primed_q;
  logic [PW-1:0] len_q;
  logic [PW-1:0] pos_inc;
  logic [PW-1:0] cur;
  logic          wrap;
  logic          len_en;

  // Next-state logic: slot of this edge, predicted slot of the next edge.
  always_comb begin
    trans    = primed_q && (frame_clk != frame_q);
    len_en   = trans && seen_q;
    pos_inc  = (pos_q == POS_MAX) ? pos_q : pos_q + POS_ONE;
    cur      = trans ? POS_ONE : pos_inc;
    seen_eff = seen_q | trans;
    ok_eff   = ok_q | len_en;
    len_eff  = len_en ? pos_q : len_q;
    wrap     = ok_eff && (cur == len_eff);
    nxt_idx  = wrap ? IDX_ONE : ({1'b0, cur} + IDX_ONE);
    nxt_level = wrap ? ~frame_clk : frame_clk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= 1'b0;
      primed_q <= 1'b0;
      pos_q    <= '0;
      seen_q   <= 1'b0;
      ok_q     <= 1'b0;
      len_q    <= '0;
    end else begin
      frame_q  <= frame_clk;
      primed_q <= 1'b1;
      pos_q    <= cur;
      seen_q   <= seen_eff;
      ok_q     <= ok_eff;
      if (len_en) begin
        len_q <= pos_q;
      end
    end
  end

endmodule

// File: rtl/pcm_bit_pick.sv
module pcm_bit_pick
  import pcm_tx_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int PW     = 7
) (
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        wlen_sel,
  input  logic              seen_eff,
  input  logic              ok_eff,
  input  logic [PW-1:0]     len_eff,
  input  logic [PW:0]       nxt_idx,
  input  logic              nxt_level,
  input  logic [DATA_W-1:0] left_q,
  input  logic [DATA_W-1:0] right_q,
  output logic              bit_d
);

  frame_fmt_e        fmt;
  int                idx_i;
  int                len_i;
  int                w_i;
  int                k_i;
  logic              allow;
  logic              left_ch;
  logic [DATA_W-1:0] smp;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    fmt     = frame_fmt_e'(fmt_sel);
    idx_i   = int'(nxt_idx);
    len_i   = int'(len_eff);
    w_i     = word_bits(wlen_sel, DATA_W);
    left_ch = fmt_sel[1] ? ~nxt_level : nxt_level;
    smp     = left_ch ? left_q : right_q;
    allow   = 1'b0;
    k_i     = -1;
    case (fmt)
      FMT_LJ: begin
        allow = ok_eff;
        k_i   = idx_i - 1;
      end
      FMT_RJ: begin
        allow = ok_eff && (len_i >= w_i);
        k_i   = idx_i - (len_i - w_i) - 1;
      end
      default: begin
        allow = seen_eff;
        k_i   = idx_i - 2;
      end
    endcase
    shifted = '0;
    bit_d   = 1'b0;
    if (allow && (k_i >= 0) && (k_i < w_i)) begin
      shifted = smp << k_i;
      bit_d   = shifted[DATA_W-1];
    end
  end

endmodule

// File: rtl/pcm_out_stage.sv
module pcm_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_d,
  output logic sdata
);

  logic bit_q;
  logic line_q;

  // Bit for the next slot, decided at the rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
    end
  end

  // Launched onto the line at the following falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
    end else begin
      line_q <= bit_q;
    end
  end

  assign sdata = line_q;

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int DATA_W   = 24,
  parameter int MAX_HALF = 64
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              frame_clk,
  input  logic              load,
  input  logic [DATA_W-1:0] left_smp,
  input  logic [DATA_W-1:0] right_smp,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        wlen_sel,
  output logic              sdata
);

  localparam int PW = $clog2(MAX_HALF + 1);

  logic              rst_sync_n;
  logic              trans;
  logic              seen_eff;
  logic              ok_eff;
  logic [PW-1:0]     len_eff;
  logic [PW:0]       nxt_idx;
  logic              nxt_level;
  logic              seen_q;
  logic              ok_q;
  logic [PW-1:0]     pos_q;
  logic              bit_d;
  logic [DATA_W-1:0] left_q;
  logic [DATA_W-1:0] right_q;
  logic [DATA_W-1:0] left_d;
  logic [DATA_W-1:0] right_d;

  pcm_rst_sync u_rst_sync (
    .clk    (bclk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // Sample pair holding register, written only under the load enable.
  always_comb begin
    left_d  = load ? left_smp  : left_q;
    right_d = load ? right_smp : right_q;
  end

  always_ff @(posedge bclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else begin
      left_q  <= left_d;
      right_q <= right_d;
    end
  end

  pcm_frame_track #(.PW(PW)) u_track (
    .clk       (bclk),
    .rst_n     (rst_sync_n),
    .frame_clk (frame_clk),
    .trans     (trans),
    .seen_eff  (seen_eff),
    .ok_eff    (ok_eff),
    .len_eff   (len_eff),
    .nxt_idx   (nxt_idx),
    .nxt_level (nxt_level),
    .seen_q    (seen_q),
    .ok_q      (ok_q),
    .pos_q     (pos_q)
  );

  pcm_bit_pick #(.DATA_W(DATA_W), .PW(PW)) u_pick (
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .seen_eff  (seen_eff),
    .ok_eff    (ok_eff),
    .len_eff   (len_eff),
    .nxt_idx   (nxt_idx),
    .nxt_level (nxt_level),
    .left_q    (left_q),
    .right_q   (right_q),
    .bit_d     (bit_d)
  );

  pcm_out_stage u_out (
    .clk   (bclk),
    .rst_n (rst_sync_n),
    .bit_d (bit_d),
    .sdata (sdata)
  );

endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arst_n,
  input logic [1:0]    fmt_sel,
  input logic          sdata,
  input logic          trans,
  input logic          seen_q,
  input logic          ok_q,
  input logic [PW-1:0] pos_q
);

  // R1: line held low while the external reset is active
  always @(negedge clk) begin
    if (!arst_n) begin
      p_low_in_reset_r1: assert (sdata == 1'b0)
        else $error("sdata high during reset");
    end
  end

  // R1: nothing is sent before a frame edge has been seen
  p_quiet_until_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (sdata == 1'b0));

  // R2: a sampled frame-clock change restarts slot counting at slot 1
  p_slot_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trans |=> (pos_q == PW'(1)));

  // R8: justified framings stay silent until a half-frame length is known
  p_len_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fmt_sel[1] && (fmt_sel == $past(fmt_sel)) && !ok_q) |-> (sdata == 1'b0));

  // R8: a length measurement needs a prior frame edge
  p_measure_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> seen_q);

  // R4: in I2S the first slot of each half-frame carries no data
  p_i2s_first_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_sel[1] && (fmt_sel == $past(fmt_sel)) && trans) |-> (sdata == 1'b0));

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.PW(PW)) u_chk (
  .clk     (bclk),
  .rst_n   (rst_sync_n),
  .arst_n  (rst_n),
  .fmt_sel (fmt_sel),
  .sdata   (sdata),
  .trans   (trans),
  .seen_q  (seen_q),
  .ok_q    (ok_q),
  .pos_q   (pos_q)
);

// File: tb/test_pcm_serial_tx.sv
module test_pcm_serial_tx;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;
  localparam int HALVES     = 6;

  // fields: fmt[59:58] wlen[57:56] half length[55:48] left[47:24] right[23:0]
  localparam logic [59:0] VECS [NVEC] = '{
    {2'd1, 2'd0, 8'd32, 24'hA5C3F0, 24'h3C96E1},
    {2'd1, 2'd2, 8'd24, 24'h81F00F, 24'h7E0FF1},
    {2'd0, 2'd1, 8'd32, 24'hC0FFEE, 24'h123456},
    {2'd0, 2'd2, 8'd24, 24'h9ABCDE, 24'h600D5A},
    {2'd0, 2'd0, 8'd20, 24'hF1E2D3, 24'h0A1B2C},
    {2'd2, 2'd2, 8'd32, 24'hB4D2E1, 24'h4B2D1E},
    {2'd2, 2'd1, 8'd21, 24'h13579B, 24'hECA864},
    {2'd3, 2'd3, 8'd25, 24'h55AA33, 24'hCC0F96},
    {2'd0, 2'd1, 8'd16, 24'hFFFFFF, 24'hFFFFFF},
    {2'd1, 2'd3, 8'd28, 24'h0F0F0F, 24'hE7184D}
  };

  logic        bclk;
  logic        rst_n;
  logic        frame_clk;
  logic        load;
  logic [23:0] left_smp;
  logic [23:0] right_smp;
  logic [1:0]  fmt_sel;
  logic [1:0]  wlen_sel;
  logic        sdata;

  int          checks;
  int          failures;
  bit          done;
  logic [23:0] cur_l;
  logic [23:0] cur_r;

  pcm_serial_tx i_pcm_serial_tx (
    .bclk      (bclk),
    .rst_n     (rst_n),
    .frame_clk (frame_clk),
    .load      (load),
    .left_smp  (left_smp),
    .right_smp (right_smp),
    .fmt_sel   (fmt_sel),
    .wlen_sel  (wlen_sel),
    .sdata     (sdata)
  );

  initial bclk = 1'b0;
  always #(CLK_PERIOD / 2) bclk = ~bclk;

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // Expected line value for slot i of half-frame h, from the requirements.
  function automatic logic exp_bit(input int fmt, input int wl, input int n, input int i,
                                   input logic level, input int h,
                                   input logic [23:0] l, input logic [23:0] r);
    int   w;
    int   k;
    logic i2s;
    logic [23:0] s;
    w   = (wl == 0) ? 16 : (wl == 1) ? 20 : 24;
    i2s = (fmt >= 2);
    s   = ((i2s && !level) || (!i2s && level)) ? l : r;
    if (!i2s && (h == 1 || (h == 2 && i == 1))) return 1'b0;
    if (fmt == 1)      k = i - 1;
    else if (fmt == 0) begin
      if (n < w) return 1'b0;
      k = i - (n - w) - 1;
    end else           k = i - 2;
    if (k < 0 || k >= w) return 1'b0;
    return s[23 - k];
  endfunction

  function automatic string tag_for(input int fmt, input int wl, input int n, input int h, input int i);
    int w;
    w = (wl == 0) ? 16 : (wl == 1) ? 20 : 24;
    if (fmt < 2 && (h == 1 || (h == 2 && i == 1))) return "R8";
    if (fmt == 0 && n < w) return "R9";
    if (fmt == 1) return "R3 R6 R7 R10";
    if (fmt == 0) return "R5 R6 R7 R10";
    return "R4 R6 R7 R10";
  endfunction

  // One bit slot: drive the frame level after a falling edge, check the line
  // before the next rising edge and again just after it.
  task automatic slot(input logic level, input int ld, input logic exp, input string tag);
    logic pre;
    @(negedge bclk);
    #1;
    frame_clk = level;
    if (ld == 1) begin
      load = 1'b1; left_smp = cur_l; right_smp = cur_r;
    end else if (ld == 2) begin
      load = 1'b0; left_smp = ~cur_l; right_smp = ~cur_r;
    end
    #(CLK_PERIOD / 2 - 3);
    pre = sdata;
    check(pre, exp, tag, "slot value");
    #4;
    check(sdata, pre, "R2", "line stable across rising edge");
  endtask

  task automatic run_case(input logic [59:0] v);
    int fmt;
    int wl;
    int n;
    fmt   = int'(v[59:58]);
    wl    = int'(v[57:56]);
    n     = int'(v[55:48]);
    cur_l = v[47:24];
    cur_r = v[23:0];
    fmt_sel  = v[59:58];
    wlen_sel = v[57:56];
    rst_n = 1'b0;
    load  = 1'b0;
    // R1: line low while in reset, even with a toggling frame clock
    for (int j = 0; j < 3; j++) slot(j[0] ? 1'b0 : 1'b1, 0, 1'b0, "R1");
    @(negedge bclk);
    #1;
    rst_n = 1'b1;
    frame_clk = 1'b0;
    // R1: no data before the first frame edge; R10: load then scramble inputs
    for (int j = 1; j <= 6; j++) slot(1'b0, (j == 3) ? 1 : (j == 4) ? 2 : 0, 1'b0, "R1");
    for (int h = 1; h <= HALVES; h++) begin
      for (int i = 1; i <= n; i++) begin
        slot(h[0], 0, exp_bit(fmt, wl, n, i, h[0], h, cur_l, cur_r), tag_for(fmt, wl, n, h, i));
      end
    end
  endtask

  initial begin
    checks    = 0;
    failures  = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    frame_clk = 1'b0;
    load      = 1'b0;
    left_smp  = '0;
    right_smp = '0;
    fmt_sel   = 2'd1;
    wlen_sel  = 2'd0;
    cur_l     = '0;
    cur_r     = '0;

    // Table walk: every framing and word length, boundary half-frame lengths
    for (int t = 0; t < NVEC; t++) run_case(VECS[t]);

    // Directed: reset in the middle of a half-frame clears the line at once (R1)
    run_case({2'd1, 2'd2, 8'd24, 24'hFFFFFF, 24'hFFFFFF});
    @(negedge bclk);
    #1;
    frame_clk = 1'b1;
    #(CLK_PERIOD / 2 - 3);
    check(sdata, 1'b1, "R3", "all-ones word MSB before mid-frame reset");
    #4;
    rst_n = 1'b0;
    #1;
    check(sdata, 1'b0, "R1", "line low right after reset asserts");
    @(negedge bclk);
    #2;
    check(sdata, 1'b0, "R1", "line low one slot into reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule